// File: doc/BRIEF.md
# PLL Holdover Control Sequencer

This block decides when the charge pump of a phase-locked loop must stop driving the loop filter, and when it may drive again. In automatic mode it watches a digital lock-detect flag together with a previously-locked indicator. A loss of lock from a loop that had been locked freezes the loop: the pump command goes to high impedance and the loop filter holds its voltage. The pump stays frozen until the next rising edge of the reference arrives at the phase detector. The sequencer then releases the pump and waits for lock to return before it arms again.

A two-bit pump mode field can force the pump to high impedance, to a constant source current or to a constant sink current. Any of these forced modes takes precedence over the sequencer. An external holdover mode replaces the automatic decision with a pin. The reference and the holdover pin arrive asynchronously and pass through a synchronizer. The reference then passes through a rising-edge detector, so each reference edge is seen exactly once.

The sequencer has five states:
- OFF: the automatic path is not running.
- WAIT_LOCK: the sequencer waits for lock before it arms.
- ARMED: locked, and watching for a loss of lock.
- HOLD: the pump is frozen at high impedance.
- RELEASE: the pump is driving again, and the sequencer waits for lock.

The transitions are:
- OFF→WAIT_LOCK when the automatic path becomes enabled.
- WAIT_LOCK→ARMED when lock is seen.
- ARMED→HOLD on a loss of lock while the previously-locked indicator is high and the mode field is normal.
- ARMED→WAIT_LOCK on a loss of lock in any other case.
- HOLD→RELEASE on a reference edge pulse.
- RELEASE→ARMED when lock is seen.
- Any state→OFF whenever the automatic path is disabled.

Top module: `hoc_holdover_ctrl`

## Requirements
- R1: The automatic holdover path runs only while `pll_en` is 1, `auto_hold_en` is 1 and `ext_hold_en` is 0. In any other case a loss of lock leaves `pump_cmd` at normal (2'b11) and `hold_active_n` at 1.
- R2: When `lock_det` goes low while armed and `was_locked` is 0, no holdover is entered: `pump_cmd` stays 2'b11 and `hold_active_n` stays 1.
- R3: When `lock_det` goes low while armed, `was_locked` is 1 and `pump_mode` is normal, holdover begins at the next clock edge: `pump_cmd` becomes 2'b00 (high impedance).
- R4: During holdover, only a rising edge of `ref_clk_in` ends it; changes on `lock_det` do not. The edge takes effect SYNC_STAGES+1 rising clock edges after it is presented, and the pump then returns to 2'b11.
- R5: After release, the sequencer waits for `lock_det` high before it re-arms. A further reference edge or a low `lock_det` in that wait causes no new holdover. Once it is re-armed, a loss of lock starts holdover again.
- R6: The `pump_mode` encoding is 2'b00 high impedance, 2'b01 forced source, 2'b10 forced sink and 2'b11 normal. Any non-normal value is driven on `pump_cmd`, which uses the same encoding, in every state. This includes holdover.
- R7: A loss of lock that arrives while `pump_mode` already holds the pump at high impedance (2'b00) does not start the holdover sequence.
- R8: When `pll_en` and `ext_hold_en` are both 1, holdover follows `ext_hold_pin`, with a latency of SYNC_STAGES clock edges. When `pll_en` is 0, the pin has no effect.
- R9: `hold_active_n` is 0 exactly while holdover is active, in both the automatic and the external mode. In that state a normal mode field gives `pump_cmd` 2'b00.
- R10: Each reference rising edge is counted once. A reference held high releases at most one holdover, and a later holdover waits for a fresh rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pll_en | input | 1 | Loop enabled |
| auto_hold_en | input | 1 | Select automatic holdover |
| ext_hold_en | input | 1 | Select pin-driven holdover |
| ext_hold_pin | input | 1 | Asynchronous holdover request pin |
| lock_det | input | 1 | Digital lock-detect flag |
| was_locked | input | 1 | Previously-locked indicator |
| ref_clk_in | input | 1 | Asynchronous reference at the phase detector |
| pump_mode | input | 2 | Pump mode field (00 hi-Z, 01 source, 10 sink, 11 normal) |
| pump_cmd | output | 2 | Command to the charge pump, same encoding |
| hold_active_n | output | 1 | Holdover active, active low |

## Verification
The bench builds the block with SYNC_STAGES = 2. This keeps the release latency at three edges and the pin latency at two, and the bench checks each of them at the exact edge where it lands and at the edge before. With that short pipeline, the bench walks every state and transition. It sweeps all four mode values both outside and inside holdover, and it tries both values of the previously-locked indicator at a loss of lock. It also covers each combination of enables that must block the automatic path.

// File: rtl/hoc_pkg.sv
package hoc_pkg;

    typedef enum logic [1:0] {
        PUMP_HIZ  = 2'b00,
        PUMP_UP   = 2'b01,
        PUMP_DOWN = 2'b10,
        PUMP_RUN  = 2'b11
    } pump_e;

    typedef enum logic [2:0] {
        S_OFF       = 3'd0,
        S_WAIT_LOCK = 3'd1,
        S_ARMED     = 3'd2,
        S_HOLD      = 3'd3,
        S_RELEASE   = 3'd4
    } seq_state_e;

endpackage

// File: rtl/hoc_sync.sv
module hoc_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/hoc_edge.sv
module hoc_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic pulse
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl;
    end

    assign pulse = lvl & ~prev_q;

    // R10: one pulse per rising edge
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);
endmodule

// File: rtl/hoc_fsm.sv
module hoc_fsm
    import hoc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  auto_run,
    input  logic  lock_det,
    input  logic  was_locked,
    input  logic  ref_pulse,
    input  pump_e pump_req,
    output logic  hold_auto
);
    seq_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (!auto_run) begin
            state_d = S_OFF;
        end else begin
            unique case (state_q)
                S_OFF:       state_d = S_WAIT_LOCK;
                S_WAIT_LOCK: if (lock_det) state_d = S_ARMED;
                S_ARMED: begin
                    if (!lock_det) begin
                        if (was_locked && pump_req == PUMP_RUN) state_d = S_HOLD;
                        else                                     state_d = S_WAIT_LOCK;
                    end
                end
                S_HOLD:      if (ref_pulse) state_d = S_RELEASE;
                S_RELEASE:   if (lock_det)  state_d = S_ARMED;
                default:     state_d = S_OFF;
            endcase
        end
    end

    always_comb begin
        hold_auto = auto_run && (state_q == S_HOLD);
    end

    a_r1_off_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_run |=> state_q == S_OFF);
    a_r2_no_hold_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ARMED && auto_run && !lock_det && !was_locked) |=> state_q != S_HOLD);
    a_r4_hold_until_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HOLD && auto_run && !ref_pulse) |=> state_q == S_HOLD);
    a_r5_wait_relock: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RELEASE && auto_run && !lock_det) |=> state_q == S_RELEASE);
    a_r7_no_hold_forced_hiz: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ARMED && pump_req == PUMP_HIZ) |=> state_q != S_HOLD);
endmodule

// File: rtl/hoc_holdover_ctrl.sv
module hoc_holdover_ctrl
    import hoc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pll_en,
    input  logic       auto_hold_en,
    input  logic       ext_hold_en,
    input  logic       ext_hold_pin,
    input  logic       lock_det,
    input  logic       was_locked,
    input  logic       ref_clk_in,
    input  logic [1:0] pump_mode,
    output logic [1:0] pump_cmd,
    output logic       hold_active_n
);
    localparam int NUM_ASYNC = 2;

    logic [NUM_ASYNC-1:0] async_raw, async_sync;
    logic  ref_pulse, hold_auto, auto_run, ext_mode, hold;
    pump_e mode_e, cmd_e;

    assign async_raw = {ext_hold_pin, ref_clk_in};
    assign mode_e    = pump_e'(pump_mode);
    assign auto_run  = pll_en & auto_hold_en & ~ext_hold_en;
    assign ext_mode  = pll_en & ext_hold_en;

    hoc_sync #(.STAGES(SYNC_STAGES), .WIDTH(NUM_ASYNC)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(async_raw), .q(async_sync));

    hoc_edge u_ref_edge (
        .clk(clk), .rst_n(rst_n), .lvl(async_sync[0]), .pulse(ref_pulse));

    hoc_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .auto_run(auto_run), .lock_det(lock_det),
        .was_locked(was_locked), .ref_pulse(ref_pulse), .pump_req(mode_e),
        .hold_auto(hold_auto));

    always_comb begin
        hold = ext_mode ? async_sync[1] : hold_auto;
        if (mode_e != PUMP_RUN) cmd_e = mode_e;
        else if (hold)          cmd_e = PUMP_HIZ;
        else                    cmd_e = PUMP_RUN;
    end

    assign pump_cmd      = cmd_e;
    assign hold_active_n = ~hold;

    a_r6_mode_override: assert property (@(posedge clk) disable iff (!rst_n)
        (pump_mode != 2'b11) |-> pump_cmd == pump_mode);
    a_r9_status_pump: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_active_n && pump_mode == 2'b11) |-> pump_cmd == 2'b00);
    a_r8_pin_ignored_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!pll_en) |-> hold_active_n);
endmodule

// File: tb/test_hoc_holdover_ctrl.sv
`timescale 1ns/1ps
module test_hoc_holdover_ctrl;
    logic clk = 0, rst_n = 0;
    logic pll_en = 1, auto_hold_en = 1, ext_hold_en = 0, ext_hold_pin = 0;
    logic lock_det = 0, was_locked = 0, ref_clk_in = 0;
    logic [1:0] pump_mode = 2'b11;
    logic [1:0] pump_cmd;
    logic hold_active_n;
    int checks = 0, errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    hoc_holdover_ctrl #(.SYNC_STAGES(2)) i_hoc_holdover_ctrl (
        .clk(clk), .rst_n(rst_n), .pll_en(pll_en), .auto_hold_en(auto_hold_en),
        .ext_hold_en(ext_hold_en), .ext_hold_pin(ext_hold_pin), .lock_det(lock_det),
        .was_locked(was_locked), .ref_clk_in(ref_clk_in), .pump_mode(pump_mode),
        .pump_cmd(pump_cmd), .hold_active_n(hold_active_n));

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string tag, logic [1:0] act, logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // expect: pump command and status
    task automatic expect_out(string tag, logic [1:0] cmd, logic hn);
        chk({tag, " pump"}, pump_cmd, cmd);
        chk({tag, " status"}, {1'b0, hold_active_n}, {1'b0, hn});
    endtask

    // release from hold using a fresh reference edge
    task automatic fresh_ref;
        ref_clk_in = 0; tick(3);
        ref_clk_in = 1; tick(3);
    endtask

    initial begin
        tick(2);
        expect_out("reset", 2'b11, 1);
        rst_n = 1; tick(2);
        lock_det = 1; tick(1);
        // R2: unlocked-before loss does not hold
        was_locked = 0; lock_det = 0; tick(1);
        expect_out("R2 no hold", 2'b11, 1);
        tick(3);
        expect_out("R2 still idle", 2'b11, 1);
        // R3 / R9: real holdover
        lock_det = 1; tick(1);
        was_locked = 1; lock_det = 0; tick(1);
        expect_out("R3 hold entered R9", 2'b00, 0);
        // R4: lock toggling ignored, edge latency 3
        lock_det = 1; tick(1); lock_det = 0; tick(1);
        expect_out("R4 lock ignored", 2'b00, 0);
        ref_clk_in = 1; tick(2);
        expect_out("R4 before edge", 2'b00, 0);
        tick(1);
        expect_out("R4 released", 2'b11, 1);
        // R5: wait for relock, no new holdover
        fresh_ref;
        expect_out("R5 waiting", 2'b11, 1);
        lock_det = 1; tick(1);
        lock_det = 0; tick(1);
        expect_out("R5 rearmed hold", 2'b00, 0);
        // R10: ref held high does not release again
        tick(5);
        expect_out("R10 level no release", 2'b00, 0);
        fresh_ref;
        expect_out("R10 fresh edge release", 2'b11, 1);
        lock_det = 1; tick(1);
        // R6 sweep outside hold
        for (int m = 0; m < 4; m++) begin
            pump_mode = m[1:0]; #1;
            expect_out("R6 armed sweep", m[1:0], 1);
        end
        // R7: loss while forced hi-Z
        pump_mode = 2'b00; lock_det = 0; tick(1);
        pump_mode = 2'b11; #1;
        expect_out("R7 no sequence", 2'b11, 1);
        lock_det = 1; tick(1);
        lock_det = 0; tick(1);
        // R6 sweep inside hold
        for (int m = 0; m < 4; m++) begin
            pump_mode = m[1:0]; #1;
            expect_out("R6 hold sweep R9", (m == 3) ? 2'b00 : m[1:0], 0);
        end
        fresh_ref;
        lock_det = 1; tick(1);
        // R1: auto disabled
        auto_hold_en = 0; tick(1);
        lock_det = 0; tick(2);
        expect_out("R1 auto off", 2'b11, 1);
        auto_hold_en = 1; pll_en = 0; lock_det = 1; tick(2);
        lock_det = 0; tick(2);
        expect_out("R1 pll off", 2'b11, 1);
        pll_en = 1; ext_hold_en = 1; lock_det = 1; tick(2);
        lock_det = 0; tick(2);
        expect_out("R1 ext selected", 2'b11, 1);
        // R8: pin-driven holdover
        ext_hold_pin = 1; tick(1);
        expect_out("R8 before latency", 2'b11, 1);
        tick(1);
        expect_out("R8 pin hold", 2'b00, 0);
        pump_mode = 2'b01; #1;
        expect_out("R8 R6 forced up", 2'b01, 0);
        pump_mode = 2'b11;
        ext_hold_pin = 0; tick(2);
        expect_out("R8 pin released", 2'b11, 1);
        pll_en = 0; ext_hold_pin = 1; tick(3);
        expect_out("R8 pll off ignored", 2'b11, 1);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule